// File: doc/BRIEF.md
# Majority-Vote Serial Receiver

This block recovers asynchronous serial frames from an RX line sampled on a sixteen-times oversampling tick. A frame is a low start bit, 7, 8 or 9 data bits sent least significant first, an optional parity bit and one or two high stop bits. Each bit is not taken from one sample. It is the majority of three samples placed around the middle of the bit. By default the three samples sit at phases 7, 8 and 9 of the bit. A configuration input can move the middle sample elsewhere.

A received word is held in an output register with a valid flag until the consumer pulses a read strobe. Framing, parity and overrun errors are separate flags. A break flag is raised when the line stays low for ten bit times after a missing stop bit. Two interrupt outputs, one for data and one for errors, are gated by their own enables. The baud tick comes from outside, and the transmitter is a separate block.

Top module: `serial_rx_vote`

## Requirements
- R1: Every bit, including start, parity and stop, takes the value held by at least two of its three samples, so a single disturbed sample inside the window has no effect on the received word.
- R2: The phase counts 0 to 15 from the tick that first sees the start bit low. With `cfg_spos_ovr_i` low the samples are taken at phases 7, 8 and 9. With it high they are taken at m-1, m and m+1, where m is `cfg_spos_i` clamped to the range 1..14. Line values at other phases have no effect.
- R3: If the start-bit vote is high, the receiver returns to idle and produces no word and no flag.
- R4: `cfg_dbits_i` selects the data width: 0 gives 7, 2 gives 9, and 1 or 3 give 8 bits. Data arrive least significant first and appear right-aligned on `data_o`, with the unused upper bits zero.
- R5: When parity is enabled, the bit after the last data bit is compared with the value set by `cfg_par_mode_i`: 0 even (the XOR of the data bits), 1 odd (its inverse), 2 always one, 3 always zero. A mismatch sets `par_err_o`.
- R6: In 9-bit mode no parity bit is expected, whatever `cfg_par_en_i` says, and `par_err_o` stays low.
- R7: One stop bit is checked, or two when `cfg_two_stop_i` is high. The frame completes at the tick of the third sample of the last stop bit, or of the first stop bit that votes low. A low stop vote sets `frame_err_o`. The outputs change on the clock edge of that tick.
- R8: If a frame completes while `valid_o` is still high and `rd_i` is low, `ovr_err_o` is set, the new word and its flags are dropped, and the held word is kept.
- R9: After a low stop vote, if the line is sampled low on 160 further ticks without a high sample, `brk_o` is set on the 160th. A high sample before then returns to idle without a break.
- R10: A one-cycle `rd_i` clears `valid_o` and all four error flags on the next edge. `data_o` keeps its value.
- R11: `irq_data_o` is `valid_o` gated by `data_ie_i`. `irq_err_o` is the OR of the four error flags gated by `err_ie_i`.
- R12: After reset `valid_o`, all error flags, both interrupts and `data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_dbits_i | input | 2 | Data width select |
| cfg_par_en_i | input | 1 | Parity enable |
| cfg_par_mode_i | input | 2 | Parity kind |
| cfg_two_stop_i | input | 1 | Two stop bits |
| cfg_spos_ovr_i | input | 1 | Use programmed sample position |
| cfg_spos_i | input | 4 | Programmed middle sample phase |
| data_ie_i | input | 1 | Data interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| rd_i | input | 1 | Consume held word |
| data_o | output | 9 | Received word |
| valid_o | output | 1 | Word held |
| frame_err_o | output | 1 | Stop bit low |
| par_err_o | output | 1 | Parity mismatch |
| ovr_err_o | output | 1 | Word lost to overrun |
| brk_o | output | 1 | Break seen |
| irq_data_o | output | 1 | Data interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
The hard case to reach is the placement of the samples. A clean frame decodes the same whatever the window, so it cannot show where the samples fall. The stimulus therefore drives each bit at slot resolution and inverts every phase outside the intended three-sample window, or flips exactly one phase inside it. Only a window at the right place and a true majority give the clean word. The bench decides each bit by counting the levels it drove at the window phases, so clamped positions such as 1 and 14 are checked against the bench's own count.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;

  localparam int DATA_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2, ST_BRK
  } srx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // number of data bits for the width selector
  function automatic logic [3:0] frame_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd7;
      2'd2:    return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  // parity bit the sender must place after the data
  function automatic logic par_ref(input logic [DATA_W-1:0] d, input logic [1:0] mode);
    case (mode)
      2'd0:    return ^d;
      2'd1:    return ~^d;
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // middle sample phase: automatic centre or clamped programmed value
  function automatic int mid_pick(input logic ovr, input int val, input int osr);
    if (!ovr)          return osr / 2;
    if (val < 1)       return 1;
    if (val > osr - 2) return osr - 2;
    return val;
  endfunction

endpackage

// File: rtl/srx_sync.sv
`timescale 1ns/1ps
module srx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/srx_sampler.sv
`timescale 1ns/1ps
module srx_sampler #(
  parameter int OSR  = 16,
  parameter int PH_W = $clog2(OSR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            rx_i,
  input  logic            busy_i,
  input  logic            launch_i,
  input  logic [PH_W-1:0] mid_i,
  output logic            vote_stb_o,
  output logic            vote_o
);
  import srx_pkg::*;

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] ph_now;
  logic            s_lo_q, s_md_q;
  logic            adv;

  // the launching tick is phase 0 even if the counter holds a stale value
  assign ph_now = busy_i ? phase_q : '0;
  assign adv    = tick_i & (busy_i | launch_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      s_lo_q  <= 1'b1;
      s_md_q  <= 1'b1;
    end else begin
      if (!busy_i && !launch_i)
        phase_q <= '0;
      else if (tick_i)
        phase_q <= (ph_now == PH_LAST) ? '0 : ph_now + 1'b1;
      if (adv && ph_now == mid_i - 1'b1) s_lo_q <= rx_i;
      if (adv && ph_now == mid_i)        s_md_q <= rx_i;
    end
  end

  assign vote_stb_o = adv & (ph_now == mid_i + 1'b1);
  assign vote_o     = maj3(s_lo_q, s_md_q, rx_i);
endmodule

// File: rtl/srx_frame_ctl.sv
`timescale 1ns/1ps
module srx_frame_ctl #(
  parameter int BRK_TICKS = 160,
  parameter int CNT_W     = $clog2(BRK_TICKS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic                      rx_i,
  input  logic                      vote_stb_i,
  input  logic                      vote_i,
  input  logic [1:0]                dbits_i,
  input  logic                      par_en_i,
  input  logic [1:0]                par_mode_i,
  input  logic                      two_stop_i,
  output logic                      busy_o,
  output logic                      launch_o,
  output logic                      idle_o,
  output logic                      done_o,
  output logic                      frame_err_o,
  output logic                      par_err_o,
  output logic [srx_pkg::DATA_W-1:0] data_o,
  output logic                      brk_set_o,
  output logic                      brk_wait_o,
  output logic                      false_start_o
);
  import srx_pkg::*;

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BRK_TICKS - 1);

  srx_state_e        state_q;
  logic [3:0]        idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              perr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              hit_q;
  logic [3:0]        nbits;
  logic              par_used;

  assign nbits    = frame_len(dbits_i);
  assign par_used = par_en_i & (nbits != 4'd9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      perr_q  <= 1'b0;
      cnt_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch_o) state_q <= ST_START;
        ST_START: if (vote_stb_i) begin
          if (vote_i) state_q <= ST_IDLE;
          else begin
            state_q <= ST_DATA;
            idx_q   <= '0;
            sh_q    <= '0;
            perr_q  <= 1'b0;
          end
        end
        ST_DATA: if (vote_stb_i) begin
          sh_q[idx_q] <= vote_i;
          idx_q       <= idx_q + 1'b1;
          if (idx_q == nbits - 4'd1) state_q <= par_used ? ST_PAR : ST_STOP1;
        end
        ST_PAR: if (vote_stb_i) begin
          perr_q  <= (vote_i != par_ref(sh_q, par_mode_i));
          state_q <= ST_STOP1;
        end
        ST_STOP1: if (vote_stb_i) begin
          if (!vote_i) begin
            state_q <= ST_BRK;
            cnt_q   <= '0;
            hit_q   <= 1'b0;
          end else state_q <= two_stop_i ? ST_STOP2 : ST_IDLE;
        end
        ST_STOP2: if (vote_stb_i) begin
          if (!vote_i) begin
            state_q <= ST_BRK;
            cnt_q   <= '0;
            hit_q   <= 1'b0;
          end else state_q <= ST_IDLE;
        end
        ST_BRK: if (tick_i) begin
          if (rx_i) state_q <= ST_IDLE;
          else if (!hit_q) begin
            if (cnt_q == CNT_LAST) hit_q <= 1'b1;
            else                   cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o        = (state_q == ST_IDLE);
  assign busy_o        = (state_q == ST_START) | (state_q == ST_DATA) | (state_q == ST_PAR) |
                         (state_q == ST_STOP1) | (state_q == ST_STOP2);
  assign launch_o      = idle_o & tick_i & ~rx_i;
  assign done_o        = vote_stb_i & (((state_q == ST_STOP1) & (~vote_i | ~two_stop_i)) |
                                       (state_q == ST_STOP2));
  assign frame_err_o   = ~vote_i;
  assign par_err_o     = perr_q;
  assign data_o        = sh_q;
  assign brk_wait_o    = (state_q == ST_BRK);
  assign brk_set_o     = brk_wait_o & tick_i & ~rx_i & ~hit_q & (cnt_q == CNT_LAST);
  assign false_start_o = (state_q == ST_START) & vote_stb_i & vote_i;
endmodule

// File: rtl/serial_rx_vote.sv
`timescale 1ns/1ps
module serial_rx_vote #(
  parameter int OSR      = 16,
  parameter int BRK_BITS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  rxd_i,
  input  logic [1:0]            cfg_dbits_i,
  input  logic                  cfg_par_en_i,
  input  logic [1:0]            cfg_par_mode_i,
  input  logic                  cfg_two_stop_i,
  input  logic                  cfg_spos_ovr_i,
  input  logic [$clog2(OSR)-1:0] cfg_spos_i,
  input  logic                  data_ie_i,
  input  logic                  err_ie_i,
  input  logic                  rd_i,
  output logic [8:0]            data_o,
  output logic                  valid_o,
  output logic                  frame_err_o,
  output logic                  par_err_o,
  output logic                  ovr_err_o,
  output logic                  brk_o,
  output logic                  irq_data_o,
  output logic                  irq_err_o
);
  import srx_pkg::*;

  localparam int PH_W      = $clog2(OSR);
  localparam int BRK_TICKS = OSR * BRK_BITS;

  logic              rx_s;
  logic [PH_W-1:0]   mid;
  logic              vote_stb, vote;
  logic              busy, launch, ctl_idle, done, fe_now, pe_now;
  logic              brk_set, brk_wait, false_start;
  logic [DATA_W-1:0] word;

  logic [DATA_W-1:0] data_q;
  logic              valid_q, fe_q, pe_q, ovr_q, brk_q;

  assign mid = PH_W'(mid_pick(cfg_spos_ovr_i, int'(cfg_spos_i), OSR));

  srx_sync u_sync (
    .clk (clk), .rst_n (rst_n), .d_i (rxd_i), .q_o (rx_s)
  );

  srx_sampler #(.OSR(OSR), .PH_W(PH_W)) u_samp (
    .clk (clk), .rst_n (rst_n), .tick_i (tick_i), .rx_i (rx_s),
    .busy_i (busy), .launch_i (launch), .mid_i (mid),
    .vote_stb_o (vote_stb), .vote_o (vote)
  );

  srx_frame_ctl #(.BRK_TICKS(BRK_TICKS)) u_ctl (
    .clk (clk), .rst_n (rst_n), .tick_i (tick_i), .rx_i (rx_s),
    .vote_stb_i (vote_stb), .vote_i (vote),
    .dbits_i (cfg_dbits_i), .par_en_i (cfg_par_en_i),
    .par_mode_i (cfg_par_mode_i), .two_stop_i (cfg_two_stop_i),
    .busy_o (busy), .launch_o (launch), .idle_o (ctl_idle), .done_o (done),
    .frame_err_o (fe_now), .par_err_o (pe_now), .data_o (word),
    .brk_set_o (brk_set), .brk_wait_o (brk_wait), .false_start_o (false_start)
  );

  // holding register: a read clears first, a completing frame then loads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
      ovr_q   <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      if (rd_i) begin
        valid_q <= 1'b0;
        fe_q    <= 1'b0;
        pe_q    <= 1'b0;
        ovr_q   <= 1'b0;
        brk_q   <= 1'b0;
      end
      if (done) begin
        if (valid_q && !rd_i) ovr_q <= 1'b1;
        else begin
          data_q  <= word;
          valid_q <= 1'b1;
          fe_q    <= fe_now;
          pe_q    <= pe_now;
        end
      end
      if (brk_set) brk_q <= 1'b1;
    end
  end

  assign data_o      = data_q;
  assign valid_o     = valid_q;
  assign frame_err_o = fe_q;
  assign par_err_o   = pe_q;
  assign ovr_err_o   = ovr_q;
  assign brk_o       = brk_q;
  assign irq_data_o  = valid_q & data_ie_i;
  assign irq_err_o   = (fe_q | pe_q | ovr_q | brk_q) & err_ie_i;
endmodule

// File: rtl/serial_rx_vote_chk.sv
`timescale 1ns/1ps
module serial_rx_vote_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_i,
  input logic       valid_o,
  input logic       ovr_err_o,
  input logic [8:0] data_o,
  input logic       brk_o,
  input logic       brk_wait,
  input logic       done,
  input logic       false_start,
  input logic       ctl_idle,
  input logic       vote_stb,
  input logic       busy,
  input logic [1:0] cfg_dbits_i,
  input logic       pe_now
);
  assert_vote_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vote_stb |-> busy);

  assert_false_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> ctl_idle);

  assert_nine_bit_no_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_dbits_i == 2'd2) |-> !pe_now);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ovr_keeps_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err_o) |-> $stable(data_o));

  assert_brk_from_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_o) |-> $past(brk_wait));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !done) |=> !valid_o);
endmodule

bind serial_rx_vote serial_rx_vote_chk u_chk (
  .clk (clk), .rst_n (rst_n), .rd_i (rd_i), .valid_o (valid_o),
  .ovr_err_o (ovr_err_o), .data_o (data_o), .brk_o (brk_o),
  .brk_wait (brk_wait), .done (done), .false_start (false_start),
  .ctl_idle (ctl_idle), .vote_stb (vote_stb), .busy (busy),
  .cfg_dbits_i (cfg_dbits_i), .pe_now (pe_now)
);

// File: tb/serial_rx_vote_tb.sv
`timescale 1ns/1ps
module serial_rx_vote_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, tick, rxd, par_en, two_stop, spos_ovr, data_ie, err_ie, rd;
  logic [1:0] dbits, par_mode;
  logic [3:0] spos;
  logic [8:0] data;
  logic       valid, fe, pe, ovr, brk, irq_d, irq_e;

  serial_rx_vote u_dut (
    .clk (clk), .rst_n (rst_n), .tick_i (tick), .rxd_i (rxd),
    .cfg_dbits_i (dbits), .cfg_par_en_i (par_en), .cfg_par_mode_i (par_mode),
    .cfg_two_stop_i (two_stop), .cfg_spos_ovr_i (spos_ovr), .cfg_spos_i (spos),
    .data_ie_i (data_ie), .err_ie_i (err_ie), .rd_i (rd),
    .data_o (data), .valid_o (valid), .frame_err_o (fe), .par_err_o (pe),
    .ovr_err_o (ovr), .brk_o (brk), .irq_data_o (irq_d), .irq_err_o (irq_e)
  );

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0;
  logic [8:0] e_data = '0;
  bit e_valid = 0, e_fe = 0, e_pe = 0, e_ovr = 0, e_brk = 0;

  function automatic void chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endfunction

  // reference model compared on every clock
  always @(negedge clk) if (cmp_on) begin
    chk("R4",  "data",      int'(data),  int'(e_data));
    chk("R10", "valid",     int'(valid), int'(e_valid));
    chk("R7",  "frame_err", int'(fe),    int'(e_fe));
    chk("R5",  "par_err",   int'(pe),    int'(e_pe));
    chk("R8",  "overrun",   int'(ovr),   int'(e_ovr));
    chk("R9",  "break",     int'(brk),   int'(e_brk));
    chk("R11", "irq_data",  int'(irq_d), int'(e_valid & data_ie));
    chk("R11", "irq_err",   int'(irq_e), int'((e_fe | e_pe | e_ovr | e_brk) & err_ie));
  end

  function automatic int mid_of();
    if (!spos_ovr)       return 8;
    if (int'(spos) < 1)  return 1;
    if (int'(spos) > 14) return 14;
    return int'(spos);
  endfunction

  function automatic bit pref(logic [8:0] d, logic [1:0] mode);
    int ones = 0;
    for (int i = 0; i < 9; i++) ones += int'(d[i]);
    case (mode)
      2'd0:    return bit'(ones % 2);
      2'd1:    return bit'(1 - ones % 2);
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // one oversampling slot: line set, settles through the synchroniser, one tick
  task automatic slot(input logic v);
    @(negedge clk); rxd = v;
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(posedge clk); #1 tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  task automatic do_read();
    @(negedge clk); rd = 1'b1;
    @(posedge clk); #1 rd = 1'b0;
    e_valid = 0; e_fe = 0; e_pe = 0; e_ovr = 0; e_brk = 0;
  endtask

  // glitch: 0 clean, 1 one sample flipped per bit, 2 every phase outside window inverted
  task automatic send_frame(input logic [8:0] d, input int glitch, input bit bad_par, input bit stop_low);
    int nb = (dbits == 2'd0) ? 7 : (dbits == 2'd2) ? 9 : 8;
    bit has_par = par_en && nb != 9;
    int m = mid_of();
    logic bits[$];
    logic [8:0] dm = d & 9'((1 << nb) - 1);
    logic [8:0] got = '0;
    bit gpar = 0, gstop = 0, fin = 0;
    bits.push_back(1'b0);
    for (int i = 0; i < nb; i++) bits.push_back(dm[i]);
    if (has_par) bits.push_back(pref(dm, par_mode) ^ bad_par);
    bits.push_back(!stop_low);
    if (two_stop && !stop_low) bits.push_back(1'b1);
    for (int k = 0; k < bits.size() && !fin; k++) begin
      int cnt = 0;
      for (int ph = 0; ph < 16 && !fin; ph++) begin
        logic v = bits[k];
        if (glitch == 1 && ph == m - 1 + (k % 3)) v = ~v;
        if (glitch == 2 && (ph < m - 1 || ph > m + 1) && !(k == 0 && ph == 0)) v = ~v;
        if (ph >= m - 1 && ph <= m + 1) cnt += int'(v);
        slot(v);
        if (ph == m + 1) begin
          bit dec = (cnt >= 2);
          if (k >= 1 && k <= nb) got[k-1] = dec;
          if (has_par && k == nb + 1) gpar = dec;
          if (k == bits.size() - 1) begin
            gstop = dec;
            fin = 1;
            if (e_valid) e_ovr = 1;
            else begin
              e_data  = got;
              e_valid = 1;
              e_fe    = !gstop;
              e_pe    = has_par && (gpar != pref(got, par_mode));
            end
          end
        end
      end
    end
    if (!stop_low) idle(3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; tick = 0; rxd = 1; dbits = 2'd1; par_en = 0; par_mode = 2'd0;
    two_stop = 0; spos_ovr = 0; spos = 4'd0; data_ie = 0; err_ie = 0; rd = 0;
    repeat (4) @(negedge clk);
    // R12: reset state
    chk("R12", "reset valid", int'(valid), 0);
    chk("R12", "reset data",  int'(data), 0);
    chk("R12", "reset flags", int'({fe, pe, ovr, brk, irq_d, irq_e}), 0);
    rst_n = 1;
    cmp_on = 1;
    idle(3);

    // R4: plain 8-bit word, interrupts enabled
    data_ie = 1; err_ie = 1;
    send_frame(9'h0A5, 0, 0, 0);
    @(negedge clk); chk("R4", "8-bit word", int'(data), 'hA5);
    do_read();

    // R1: one disturbed sample in every bit
    send_frame(9'h03C, 1, 0, 0);
    @(negedge clk); chk("R1", "majority word", int'(data), 'h3C);
    do_read();

    // R4: 7-bit width, upper bits zero
    dbits = 2'd0;
    send_frame(9'h1FF, 0, 0, 0);
    @(negedge clk); chk("R4", "7-bit word", int'(data), 'h7F);
    do_read();

    // R6: 9-bit mode ignores parity enable
    dbits = 2'd2; par_en = 1;
    send_frame(9'h155, 0, 0, 0);
    @(negedge clk); chk("R6", "9-bit word", int'(data), 'h155);
    chk("R6", "9-bit parity flag", int'(pe), 0);
    do_read();

    // R5: all parity kinds, correct and corrupted
    dbits = 2'd1; data_ie = 0;
    for (int md = 0; md < 4; md++) begin
      par_mode = 2'(md);
      send_frame(9'h0B3, 0, 0, 0);
      @(negedge clk); chk("R5", "good parity", int'(pe), 0);
      do_read();
      send_frame(9'h04E, 0, 1, 0);
      @(negedge clk); chk("R5", "bad parity", int'(pe), 1);
      do_read();
    end
    par_en = 0;

    // R7: two stop bits, then a missing stop bit
    two_stop = 1;
    send_frame(9'h0C6, 0, 0, 0);
    @(negedge clk); chk("R7", "two-stop frame ok", int'(fe), 0);
    do_read();
    send_frame(9'h071, 0, 0, 1);
    @(negedge clk); chk("R7", "stop low", int'(fe), 1);
    idle(4);
    do_read();
    two_stop = 0;

    // R9: short low after framing error gives no break
    send_frame(9'h000, 0, 0, 1);
    for (int i = 0; i < 40; i++) slot(1'b0);
    idle(4);
    @(negedge clk); chk("R9", "short low", int'(brk), 0);
    do_read();

    // R3: false start
    for (int i = 0; i < 6; i++) slot(1'b0);
    idle(20);
    @(negedge clk); chk("R3", "false start", int'(valid), 0);

    // R2: default window and programmed windows, hostile outside samples
    send_frame(9'h05A, 2, 0, 0);
    @(negedge clk); chk("R2", "default window", int'(data), 'h5A);
    do_read();
    spos_ovr = 1; spos = 4'd4;
    send_frame(9'h096, 2, 0, 0);
    @(negedge clk); chk("R2", "window at 4", int'(data), 'h96);
    do_read();
    spos = 4'd0;
    send_frame(9'h069, 2, 0, 0);
    @(negedge clk); chk("R2", "window clamped low", int'(data), 'h69);
    do_read();
    spos = 4'd15;
    send_frame(9'h0C3, 2, 0, 0);
    @(negedge clk); chk("R2", "window clamped high", int'(data), 'hC3);
    do_read();
    spos_ovr = 0;

    // R8: overrun keeps first word
    data_ie = 1;
    send_frame(9'h011, 0, 0, 0);
    send_frame(9'h022, 0, 0, 0);
    @(negedge clk); chk("R8", "held word", int'(data), 'h11);
    chk("R8", "overrun flag", int'(ovr), 1);
    do_read();

    // R9: break after ten low bit times
    err_ie = 0;
    send_frame(9'h000, 0, 0, 1);
    for (int i = 1; i <= 170; i++) begin
      slot(1'b0);
      if (i == 160) e_brk = 1;
    end
    @(negedge clk); chk("R9", "break", int'(brk), 1);
    chk("R11", "err irq masked", int'(irq_e), 0);
    err_ie = 1;
    idle(3);
    @(negedge clk); chk("R11", "err irq enabled", int'(irq_e), 1);
    do_read();
    @(negedge clk); chk("R10", "flags cleared", int'({valid, fe, pe, ovr, brk}), 0);

    // R4: word after break recovery
    send_frame(9'h0E7, 0, 0, 0);
    @(negedge clk); chk("R4", "after break", int'(data), 'hE7);
    do_read();
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule